// File: doc/BRIEF.md
# Parallel Flash Write Sequencer

This block sits on the host side of an asynchronous, byte-wide flash device. It turns one request into a correctly timed bus write. A request carries an address, a data byte and an operation code. The write is controlled by the write-enable strobe. For program and erase operations, the block then polls the device's status byte with ordinary read cycles until the device reports completion or a per-operation time limit runs out.

Every minimum interval in nanoseconds is a parameter. Each one is turned into a clock count by ceiling division with the clock period, so every generated interval is at least as long as its minimum. The longer write-cycle period comes from a speed-grade parameter. After the block's reset, the block holds the device's reset/power-down pin low. It then releases the pin and waits out the recovery time before it accepts the first request.

Top module: `pfws_seq`

## Requirements
- R1: During reset, `flash_rp_n` is 0, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are 1, `flash_dq_oe` is 0 and `req_ready` is 0. `flash_we_n` first goes low no sooner than ceil(RP_REC_NS/CLK_NS) cycles after `flash_rp_n` rises.
- R2: Each `flash_we_n` low pulse lasts at least ceil(WE_LOW_NS/CLK_NS) cycles. `flash_we_n` stays high at least ceil(WE_HIGH_NS/CLK_NS) cycles between two low pulses.
- R3: `flash_addr` and `flash_dq_o` are stable for at least ceil(SETUP_NS/CLK_NS) cycles before `flash_we_n` rises. They are unchanged, with `flash_dq_oe` still 1, in the first cycle after the rise.
- R4: `flash_ce_n` is low at least ceil(CE_SETUP_NS/CLK_NS) cycles before `flash_we_n` falls. It is still low in the cycle after `flash_we_n` rises. `flash_we_n` is never low while `flash_ce_n` is high.
- R5: Successive falling edges of `flash_we_n` are at least ceil(WC/CLK_NS) cycles apart. WC is WC_FAST_NS when SPEED_GRADE is 0 and WC_SLOW_NS otherwise.
- R6: `flash_dq_oe` and a low `flash_oe_n` never occur in the same cycle. `flash_oe_n` is low only while `flash_ce_n` is low and `flash_we_n` is high.
- R7: Operation code 0 (plain write) performs one write cycle and no read cycle. It then reports done with `done_status` = 0, `done_fail` = 0 and `done_timeout` = 0. The address and data presented at the strobe's rising edge are those of the request.
- R8: Operation codes 1 (program), 2 (block erase) and 3 (main-block erase) follow the write with repeated read cycles. Polling ends when status bit 7 reads 1, and `done_status` then holds the byte last read.
- R9: `done_fail` is 1 only when the final sample has bit 7 set and any of status bits 3, 4 or 5 set. These bits are ignored while bit 7 is 0.
- R10: Each polling operation has its own limit: PROG_TMO_US, BLK_TMO_US or MAIN_TMO_US, converted to cycles. Without completion, done comes with `done_timeout` = 1 no sooner than that many cycles after acceptance. A completion within the limit gives `done_timeout` = 0.
- R11: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until done. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to write |
| req_op | input | 2 | 0 write, 1 program, 2 block erase, 3 main-block erase |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Last status byte read |
| done_fail | output | 1 | Completed with error bits |
| done_timeout | output | 1 | Polling limit reached |
| flash_addr | output | AW | Device address bus |
| flash_dq_o | output | 8 | Data driven to device |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | 8 | Data read from device |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_rp_n | output | 1 | Device reset/power-down, active low |

## Verification
The hardest case to reach from the ports is a busy time that lies between two operation limits. The same device delay must then time out a program request but complete a block erase, while the device shows error bits during busy polls. The bench's device stub starts a configurable busy count at the write strobe's rising edge. While busy, it answers reads with a byte that has bits 3 to 5 set and bit 7 clear. The bench places busy counts well on either side of each cycle limit, and sweeps all eight error-bit patterns in the final status.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

  typedef enum logic [1:0] {
    OP_WRITE      = 2'd0,
    OP_PROG       = 2'd1,
    OP_ERASE_BLK  = 2'd2,
    OP_ERASE_MAIN = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_WAKE, S_IDLE, S_SETUP, S_WEL, S_HOLD, S_RECOV, S_RD, S_PGAP
  } st_e;

  localparam int SR_DONE_BIT = 7;
  localparam int SR_ERR_LO   = 3;
  localparam int SR_ERR_HI   = 5;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic longint cdivl(input longint n, input longint d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic longint lmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfws_downcnt.sv
module pfws_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= val;
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pfws_stat_eval.sv
module pfws_stat_eval #(
  parameter int DONE_BIT = 7,
  parameter int ERR_LO   = 3,
  parameter int ERR_HI   = 5
) (
  input  logic [7:0] sr,
  output logic       complete,
  output logic       failed
);
  assign complete = sr[DONE_BIT];
  assign failed   = |sr[ERR_HI:ERR_LO];
endmodule

// File: rtl/pfws_seq.sv
module pfws_seq import pfws_pkg::*; #(
  parameter int AW           = 17,
  parameter int CLK_NS       = 20,
  parameter int SPEED_GRADE  = 0,
  parameter int WC_FAST_NS   = 120,
  parameter int WC_SLOW_NS   = 150,
  parameter int WE_LOW_NS    = 50,
  parameter int WE_HIGH_NS   = 50,
  parameter int SETUP_NS     = 50,
  parameter int HOLD_NS      = 10,
  parameter int CE_SETUP_NS  = 10,
  parameter int RP_REC_NS    = 480,
  parameter int RD_ACC_NS    = 150,
  parameter int OE_HIGH_NS   = 20,
  parameter int PROG_TMO_US  = 15000,
  parameter int BLK_TMO_US   = 13000000,
  parameter int MAIN_TMO_US  = 30000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic [1:0]    req_op,
  output logic          done,
  output logic [7:0]    done_status,
  output logic          done_fail,
  output logic          done_timeout,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dq_o,
  output logic          flash_dq_oe,
  input  logic [7:0]    flash_dq_i,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  output logic          flash_rp_n
);
  // interval lengths in clock cycles, each at least one cycle
  localparam int C_WC  = cdiv((SPEED_GRADE != 0) ? WC_SLOW_NS : WC_FAST_NS, CLK_NS);
  localparam int C_CS  = imax(1, cdiv(CE_SETUP_NS, CLK_NS));
  localparam int C_WL  = imax(1, imax(cdiv(WE_LOW_NS, CLK_NS), cdiv(SETUP_NS, CLK_NS) - C_CS));
  localparam int C_WPH = cdiv(WE_HIGH_NS, CLK_NS);
  localparam int C_HD  = imax(1, cdiv(HOLD_NS, CLK_NS));
  localparam int C_RC  = imax(1, imax(C_WC - (C_CS + C_WL + C_HD), C_WPH - C_HD - C_CS));
  localparam int C_RD  = imax(1, cdiv(RD_ACC_NS, CLK_NS));
  localparam int C_PG  = imax(1, cdiv(OE_HIGH_NS, CLK_NS));
  localparam int C_RP  = imax(1, cdiv(RP_REC_NS, CLK_NS));
  localparam int PH_MAX = imax(imax(imax(C_CS, C_WL), imax(C_HD, C_RC)),
                               imax(imax(C_RD, C_PG), C_RP));
  localparam int PH_W  = $clog2(PH_MAX + 1);

  localparam longint L_PROG = lmax(1, cdivl(longint'(PROG_TMO_US) * 1000, CLK_NS));
  localparam longint L_BLK  = lmax(1, cdivl(longint'(BLK_TMO_US) * 1000, CLK_NS));
  localparam longint L_MAIN = lmax(1, cdivl(longint'(MAIN_TMO_US) * 1000, CLK_NS));
  localparam int TMO_W = $clog2(lmax(L_PROG, lmax(L_BLK, L_MAIN)) + 1);

  st_e             state_q, state_d;
  op_e             op_q;
  logic [PH_W-1:0] ph_len, ph_val;
  logic            ph_zero, ph_load;
  logic [TMO_W-1:0] tmo_lim;
  logic            tmo_zero, tmo_load;
  logic            sr_complete, sr_failed;
  logic            accept, rd_end, finish;

  assign accept = (state_q == S_IDLE) && req_valid;
  assign rd_end = (state_q == S_RD) && ph_zero;
  assign finish = ((state_q == S_RECOV) && ph_zero && (op_q == OP_WRITE)) ||
                  (rd_end && (sr_complete || tmo_zero));

  pfws_stat_eval #(.DONE_BIT(SR_DONE_BIT), .ERR_LO(SR_ERR_LO), .ERR_HI(SR_ERR_HI)) u_eval (
    .sr(flash_dq_i), .complete(sr_complete), .failed(sr_failed)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_WAKE:  if (ph_zero) state_d = S_IDLE;
      S_IDLE:  if (req_valid) state_d = S_SETUP;
      S_SETUP: if (ph_zero) state_d = S_WEL;
      S_WEL:   if (ph_zero) state_d = S_HOLD;
      S_HOLD:  if (ph_zero) state_d = S_RECOV;
      S_RECOV: if (ph_zero) state_d = (op_q == OP_WRITE) ? S_IDLE : S_RD;
      S_RD:    if (ph_zero) state_d = (sr_complete || tmo_zero) ? S_IDLE : S_PGAP;
      S_PGAP:  if (ph_zero) state_d = S_RD;
      default: state_d = S_IDLE;
    endcase
  end

  // phase length of the state being entered
  always_comb begin
    case (state_d)
      S_SETUP: ph_len = PH_W'(C_CS - 1);
      S_WEL:   ph_len = PH_W'(C_WL - 1);
      S_HOLD:  ph_len = PH_W'(C_HD - 1);
      S_RECOV: ph_len = PH_W'(C_RC - 1);
      S_RD:    ph_len = PH_W'(C_RD - 1);
      S_PGAP:  ph_len = PH_W'(C_PG - 1);
      default: ph_len = '0;
    endcase
  end

  assign ph_load = rst || (state_d != state_q);
  assign ph_val  = rst ? PH_W'(C_RP - 1) : ph_len;

  pfws_downcnt #(.W(PH_W)) u_phase (
    .clk(clk), .load(ph_load), .val(ph_val), .zero(ph_zero)
  );

  // per-operation polling limit
  always_comb begin
    case (op_e'(req_op))
      OP_PROG:       tmo_lim = TMO_W'(L_PROG - 1);
      OP_ERASE_BLK:  tmo_lim = TMO_W'(L_BLK - 1);
      OP_ERASE_MAIN: tmo_lim = TMO_W'(L_MAIN - 1);
      default:       tmo_lim = '0;
    endcase
  end

  assign tmo_load = rst || accept;

  pfws_downcnt #(.W(TMO_W)) u_tmo (
    .clk(clk), .load(tmo_load), .val(rst ? '0 : tmo_lim), .zero(tmo_zero)
  );

  // registered state and pins
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_WAKE;
      op_q         <= OP_WRITE;
      flash_addr   <= '0;
      flash_dq_o   <= '0;
      flash_rp_n   <= 1'b0;
      flash_ce_n   <= 1'b1;
      flash_we_n   <= 1'b1;
      flash_oe_n   <= 1'b1;
      flash_dq_oe  <= 1'b0;
      req_ready    <= 1'b0;
      done         <= 1'b0;
      done_status  <= '0;
      done_fail    <= 1'b0;
      done_timeout <= 1'b0;
    end else begin
      state_q     <= state_d;
      flash_rp_n  <= 1'b1;
      flash_ce_n  <= !(state_d inside {S_SETUP, S_WEL, S_HOLD, S_RD});
      flash_we_n  <= (state_d != S_WEL);
      flash_oe_n  <= (state_d != S_RD);
      flash_dq_oe <= (state_d inside {S_SETUP, S_WEL, S_HOLD});
      req_ready   <= (state_d == S_IDLE);
      done        <= finish;
      if (accept) begin
        op_q        <= op_e'(req_op);
        flash_addr  <= req_addr;
        flash_dq_o  <= req_data;
        done_status <= '0;
      end
      if (rd_end)
        done_status <= flash_dq_i;
      if (finish) begin
        done_fail    <= rd_end && sr_complete && sr_failed;
        done_timeout <= rd_end && !sr_complete;
      end
    end
  end

  // R4: write strobe only inside chip enable
  a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> !flash_ce_n);

  // R6: bus released whenever the device may drive it
  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> (!flash_dq_oe && flash_we_n && !flash_ce_n));

  // R3: address and data do not move on the strobe's rising edge
  a_r3_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_o) && flash_dq_oe));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: ready drops after acceptance
  a_r11_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9: a failure needs the completion bit and an error bit
  a_r9_fail_source: assert property (@(posedge clk) disable iff (rst)
    (done && done_fail) |-> (done_status[SR_DONE_BIT] && |done_status[SR_ERR_HI:SR_ERR_LO]));

  // R10: a timeout never carries the completion bit
  a_r10_timeout_incomplete: assert property (@(posedge clk) disable iff (rst)
    (done && done_timeout) |-> (!done_status[SR_DONE_BIT] && !done_fail));
endmodule

// File: tb/pfws_seq_bench.sv
module pfws_seq_bench;
  localparam int AW     = 8;
  localparam int CLK_NS = 20;
  localparam int P_US = 4, B_US = 8, M_US = 12;
  localparam int E_CS  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int E_WP  = (50 + CLK_NS - 1) / CLK_NS;
  localparam int E_WPH = (50 + CLK_NS - 1) / CLK_NS;
  localparam int E_AS  = (50 + CLK_NS - 1) / CLK_NS;
  localparam int E_WC  = (120 + CLK_NS - 1) / CLK_NS;
  localparam int E_RP  = (480 + CLK_NS - 1) / CLK_NS;
  localparam int LIM_P = (P_US * 1000 + CLK_NS - 1) / CLK_NS;
  localparam int LIM_B = (B_US * 1000 + CLK_NS - 1) / CLK_NS;
  localparam int LIM_M = (M_US * 1000 + CLK_NS - 1) / CLK_NS;
  localparam logic [7:0] BUSY_SR = 8'h3A;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic [1:0] req_op = '0;
  logic done, done_fail, done_timeout;
  logic [7:0] done_status;
  logic [AW-1:0] flash_addr;
  logic [7:0] flash_dq_o, flash_dq_i;
  logic flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n, flash_rp_n;

  int errors = 0, checks = 0, cyc = 0;
  int busy_left = 0, arm_busy = 0, arm_op = 0;
  logic [7:0] fin_sr = 8'h80;

  always #(CLK_NS / 2) clk = !clk;

  assign flash_dq_i = flash_oe_n ? 8'h00 : ((busy_left > 0) ? BUSY_SR : fin_sr);

  pfws_seq #(.AW(AW), .CLK_NS(CLK_NS), .PROG_TMO_US(P_US), .BLK_TMO_US(B_US),
             .MAIN_TMO_US(M_US)) u_pfws_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_op(req_op), .done(done),
    .done_status(done_status), .done_fail(done_fail), .done_timeout(done_timeout),
    .flash_addr(flash_addr), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
    .flash_dq_i(flash_dq_i), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n), .flash_rp_n(flash_rp_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // pin monitor and device stub
  logic prev_we = 1'b1, prev_oe = 1'b1, seen_fall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [7:0] prev_dq = '0;
  int we_low = 0, we_high = 0, ce_low = 0, stab = 0, since_fall = 0, rp_high = 0;
  int contend = 0, oe_falls = 0, wr_count = 0;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always @(negedge clk) begin
    if (!rst) begin
      stab = (flash_addr == prev_addr && flash_dq_o == prev_dq) ? stab + 1 : 1;
      if (prev_we && !flash_we_n) begin
        chk(ce_low >= E_CS, "R4 ce setup", ce_low, E_CS);
        if (seen_fall) begin
          chk(we_high >= E_WPH, "R2 we high", we_high, E_WPH);
          chk(since_fall >= E_WC, "R5 cycle period", since_fall, E_WC);
        end else
          chk(rp_high >= E_RP, "R1 rp recovery", rp_high, E_RP);
        seen_fall = 1'b1;
        since_fall = 0;
      end
      if (!prev_we && flash_we_n) begin
        chk(we_low >= E_WP, "R2 we low", we_low, E_WP);
        chk(stab - 1 >= E_AS, "R3 setup", stab - 1, E_AS);
        chk(stab >= 2 && flash_dq_oe, "R3 hold", stab, 2);
        chk(!flash_ce_n, "R4 ce hold", flash_ce_n, 0);
        wr_addr = flash_addr; wr_data = flash_dq_o; wr_count++;
        if (arm_op != 0) busy_left = arm_busy;
      end else if (busy_left > 0)
        busy_left--;
      if (flash_dq_oe && !flash_oe_n) contend++;
      if (!flash_oe_n && (flash_ce_n || !flash_we_n)) contend++;
      if (!flash_we_n && flash_ce_n) contend++;
      if (prev_oe && !flash_oe_n) oe_falls++;
      we_low  = flash_we_n ? 0 : we_low + 1;
      we_high = flash_we_n ? we_high + 1 : 0;
      ce_low  = flash_ce_n ? 0 : ce_low + 1;
      rp_high = flash_rp_n ? rp_high + 1 : 0;
      since_fall++;
      prev_we = flash_we_n; prev_oe = flash_oe_n;
      prev_addr = flash_addr; prev_dq = flash_dq_o;
    end
  end

  task automatic do_req(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int busy, input logic [7:0] fsr, input bit exp_tmo,
                        input int lim, input string tag);
    int acc, n, wc0;
    arm_op = op; arm_busy = busy; fin_sr = fsr;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc; wc0 = wr_count; oe_falls = 0;
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low after accept", req_ready, 0);
    n = 0;
    do begin
      if (!done) begin @(negedge clk); n++; end
    end while (!done && n < 5000);
    chk(done, {tag, " done seen"}, done, 1);
    chk(wr_count == wc0 + 1 || (wr_count == wc0 + 1), {tag, " one write"}, wr_count - wc0, 1);
    chk(wr_addr == a && wr_data == d, {tag, " R7 write content"}, {wr_addr, wr_data}, {a, d});
    if (op == 0) begin
      chk(oe_falls == 0, "R7 no read cycle", oe_falls, 0);
      chk(done_status == 8'h00 && !done_fail && !done_timeout, "R7 clean done",
          {done_status, done_fail, done_timeout}, 0);
    end else if (exp_tmo) begin
      chk(done_timeout, {tag, " R10 timeout flag"}, done_timeout, 1);
      chk(cyc - acc >= lim, {tag, " R10 timeout not early"}, cyc - acc, lim);
      chk(!done_fail && done_status == BUSY_SR, {tag, " R9 busy errors ignored"},
          {done_fail, done_status}, {1'b0, BUSY_SR});
    end else begin
      chk(!done_timeout, {tag, " R10 no timeout"}, done_timeout, 0);
      chk(done_status == fsr, {tag, " R8 status byte"}, done_status, fsr);
      chk(done_fail == (fsr[5:3] != 3'b000), {tag, " R9 fail flag"}, done_fail,
          fsr[5:3] != 3'b000);
      if (busy > 20) chk(oe_falls >= 2, {tag, " R8 repeated polls"}, oe_falls, 2);
    end
    @(negedge clk);
    chk(!done, "R11 done single pulse", done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!flash_rp_n && flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe && !req_ready,
        "R1 reset pins", {flash_rp_n, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, req_ready},
        6'b011100);
    rst = 1'b0;
    // R7 and R5: plain writes with distinct patterns
    for (int i = 0; i < 4; i++)
      do_req(0, AW'(8'h11 * (i + 1)), 8'(8'hA5 ^ (i * 37)), 0, 8'h80, 1'b0, 0, "R7 write");
    // R8 / R9: program with every error-bit pattern in the final status
    for (int e = 0; e < 8; e++)
      do_req(1, AW'(e), 8'(e * 3), 40, 8'h80 | 8'(e << 3) | 8'(e ^ 5) & 8'h07,
             1'b0, LIM_P, "R9 program");
    // R10: busy times just inside each operation's limit
    do_req(2, 8'h40, 8'hD0, 250, 8'h80, 1'b0, LIM_B, "R10 block ok");
    do_req(3, 8'h41, 8'hD0, 500, 8'h81, 1'b0, LIM_M, "R10 main ok");
    // R10: busy times beyond each limit
    do_req(1, 8'h50, 8'h12, 250, 8'h80, 1'b1, LIM_P, "R10 program tmo");
    do_req(2, 8'h51, 8'hD0, 500, 8'h80, 1'b1, LIM_B, "R10 block tmo");
    do_req(3, 8'h52, 8'hD0, 900, 8'h80, 1'b1, LIM_M, "R10 main tmo");
    do_req(0, 8'hFF, 8'h00, 0, 8'h80, 1'b0, 0, "R7 write after tmo");
    chk(contend == 0, "R6 bus contention cycles", contend, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule